// File: doc/BRIEF.md
# Protected Processor Mode Register

An 8-bit control register on a simple CPU-side bus that holds the processor's memory-area mode, reserved-area expansion, wait insertion, watchdog action select, data-block enable and port/address pin select. A write goes in only when it targets the register's address and the external protect-enable input is high. Software can set the watchdog action bit but never clear it. While a flash-rewrite status input is high, the data-block enable and the reserved-area expansion bits are held at 1.

The two-bit memory-area field is kept as a two-state machine with the states `AREA_1M` (code 00) and `AREA_4M` (code 11). The named transitions are `LOAD_1M` (an accepted write with code 00 enters `AREA_1M`), `LOAD_4M` (an accepted write with code 11 enters `AREA_4M`) and `HOLD` (an accepted write with code 01 or 10 leaves the state unchanged and sets a sticky error flag). Every field is also brought out as a decoded output.

Top module: `pmr_ctrl`

## Requirements
- R1: After reset, a read of the register address (REG_ADDR, default 0) returns 0x08. A read of the error address (REG_ADDR+1) returns 0x00, and area_err is 0.
- R2: A write has no effect unless wr_en is 1, addr equals REG_ADDR and prot_wen is 1, all in the same cycle.
- R3: Bit 2 (wdt_rst_sel, 1 = watchdog reset, 0 = watchdog interrupt) is set by an accepted write with a 1 in that bit. Writing 0 leaves it at 1 until reset.
- R4: While flash_rw is 1, bit 0 (blk_en) and bit 3 (rsv_exp) read 1 from the clock edge after flash_rw rises, even if an accepted write carries 0 in those bits.
- R5: When flash_rw falls, bits 0 and 3 stay 1 until an accepted write changes them.
- R6: Bits 5:4 hold the area code. An accepted write of 00 selects 1-Mbyte mode (area_4m = 0) and a write of 11 selects 4-Mbyte mode (area_4m = 1).
- R7: An accepted write of 01 or 10 to bits 5:4 leaves the field unchanged and sets area_err. The error also reads back as bit 0 at address REG_ADDR+1, and it stays set until reset.
- R8: Bit 6 always reads 0, whatever was written to it.
- R9: Bit 1 (port_sel) and bit 7 (wait_en) are plain read/write bits that load from each accepted write.
- R10: A read at any address other than REG_ADDR or REG_ADDR+1 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| prot_wen | input | 1 | Protect-enable; writes are accepted only while 1 |
| flash_rw | input | 1 | Flash-rewrite mode status |
| blk_en | output | 1 | Data-block enable (bit 0) |
| port_sel | output | 1 | Port function instead of address output (bit 1) |
| wdt_rst_sel | output | 1 | Watchdog action: 1 reset, 0 interrupt (bit 2) |
| rsv_exp | output | 1 | Internal reserved-area expansion (bit 3) |
| area_4m | output | 1 | 4-Mbyte area mode selected |
| wait_en | output | 1 | One wait state inserted (bit 7) |
| area_err | output | 1 | Sticky illegal-area-code flag |

## Verification
On every cycle the assertions check the following. The stored image stays still when no write can be accepted and no flash forcing is active. The watchdog bit never falls and the forced bits rise after flash_rw. The area field only ever holds a legal code, an illegal code write keeps the state and raises the sticky flag, and bit 6 reads 0. Only the bench scenarios can show the rest: each write path lands in the correct field, a write to the wrong address is ignored, the forced bits stay 1 after flash_rw falls, and the error flag reads back at its own address.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
    typedef enum logic [1:0] {
        AREA_1M = 2'b00,
        AREA_4M = 2'b11
    } area_e;

    localparam int unsigned DATA_W   = 8;
    localparam logic [7:0]  RST_IMG  = 8'h08;
    localparam logic [7:0]  RSV_MASK = 8'hBF;
endpackage

// File: rtl/pmr_bus_decode.sv
module pmr_bus_decode #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned REG_ADDR = 0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              prot_wen,
    output logic              wr_acc,
    output logic              sel_main,
    output logic              sel_err
);
    localparam logic [ADDR_W-1:0] MAIN_A = ADDR_W'(REG_ADDR);
    localparam logic [ADDR_W-1:0] ERR_A  = ADDR_W'(REG_ADDR + 1);

    always_comb begin
        sel_main = (addr == MAIN_A);
        sel_err  = (addr == ERR_A);
        wr_acc   = wr_en && prot_wen && sel_main;
    end
endmodule

// File: rtl/pmr_area_fsm.sv
module pmr_area_fsm
    import pmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_acc,
    input  logic [1:0] code,
    output logic [1:0] area_code,
    output logic       area_4m,
    output logic       area_err
);
    area_e state_q, state_d;
    logic  err_q, err_set;

    // next state: LOAD_1M, LOAD_4M, HOLD
    always_comb begin
        state_d = state_q;
        err_set = 1'b0;
        if (wr_acc) begin
            unique case (code)
                2'b00:   state_d = AREA_1M;
                2'b11:   state_d = AREA_4M;
                default: err_set = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AREA_1M;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_q | err_set;
        end
    end

    always_comb begin
        area_code = state_q;
        area_4m   = (state_q == AREA_4M);
        area_err  = err_q;
    end

    assert_area_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (area_code == 2'b00) || (area_code == 2'b11));

    assert_illegal_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && (code[1] != code[0])) |=> ($stable(area_code) && area_err));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        area_err |=> area_err);
endmodule

// File: rtl/pmr_bit_cells.sv
module pmr_bit_cells (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_acc,
    input  logic flash_rw,
    input  logic w_blk,
    input  logic w_port,
    input  logic w_wdt,
    input  logic w_exp,
    input  logic w_wait,
    output logic blk_q,
    output logic port_q,
    output logic wdt_q,
    output logic exp_q,
    output logic wait_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q  <= 1'b0;
            port_q <= 1'b0;
            wdt_q  <= 1'b0;
            exp_q  <= 1'b1;
            wait_q <= 1'b0;
        end else begin
            if (wr_acc) begin
                blk_q  <= w_blk;
                port_q <= w_port;
                wdt_q  <= wdt_q | w_wdt;
                exp_q  <= w_exp;
                wait_q <= w_wait;
            end
            if (flash_rw) begin
                blk_q <= 1'b1;
                exp_q <= 1'b1;
            end
        end
    end

    assert_wdt_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_q |=> wdt_q);

    assert_flash_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rw |=> (blk_q && exp_q));
endmodule

// File: rtl/pmr_ctrl.sv
module pmr_ctrl
    import pmr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned REG_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              prot_wen,
    input  logic              flash_rw,
    output logic              blk_en,
    output logic              port_sel,
    output logic              wdt_rst_sel,
    output logic              rsv_exp,
    output logic              area_4m,
    output logic              wait_en,
    output logic              area_err
);
    logic       wr_acc, sel_main, sel_err;
    logic [7:0] wimg;
    logic [1:0] area_code;
    logic [7:0] reg_img;

    assign wimg = wdata & RSV_MASK;

    pmr_bus_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) dec_i (
        .wr_en    (wr_en),
        .addr     (addr),
        .prot_wen (prot_wen),
        .wr_acc   (wr_acc),
        .sel_main (sel_main),
        .sel_err  (sel_err)
    );

    pmr_area_fsm area_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_acc    (wr_acc),
        .code      (wimg[5:4]),
        .area_code (area_code),
        .area_4m   (area_4m),
        .area_err  (area_err)
    );

    pmr_bit_cells bits_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_acc   (wr_acc),
        .flash_rw (flash_rw),
        .w_blk    (wimg[0]),
        .w_port   (wimg[1]),
        .w_wdt    (wimg[2]),
        .w_exp    (wimg[3]),
        .w_wait   (wimg[7]),
        .blk_q    (blk_en),
        .port_q   (port_sel),
        .wdt_q    (wdt_rst_sel),
        .exp_q    (rsv_exp),
        .wait_q   (wait_en)
    );

    always_comb begin
        reg_img = {wait_en, wimg[6], area_code, rsv_exp, wdt_rst_sel, port_sel, blk_en};
        if (sel_main)     rdata = reg_img;
        else if (sel_err) rdata = {7'b0, area_err};
        else              rdata = 8'h00;
    end

    assert_no_write_unprotected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_wen && !flash_rw) |=> $stable(reg_img));

    assert_rsv_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[6] == 1'b0);
endmodule

// File: tb/pmr_ctrl_tb_top.sv
module pmr_ctrl_tb_top;
    localparam int ADDR_W = 4;
    localparam int NVEC   = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = 8'h00;
    logic [7:0]        rdata;
    logic              prot_wen = 1'b0;
    logic              flash_rw = 1'b0;
    logic blk_en, port_sel, wdt_rst_sel, rsv_exp, area_4m, wait_en, area_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pmr_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .prot_wen(prot_wen), .flash_rw(flash_rw),
        .blk_en(blk_en), .port_sel(port_sel), .wdt_rst_sel(wdt_rst_sel),
        .rsv_exp(rsv_exp), .area_4m(area_4m), .wait_en(wait_en), .area_err(area_err)
    );

    // {prot, flash, wr, addr[3:0], wdata[7:0], exp_rd[7:0], exp_err}
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b1, 4'h0, 8'h82, 8'h82, 1'b0}, // R9 plain bits
        {1'b0, 1'b0, 1'b1, 4'h0, 8'h00, 8'h82, 1'b0}, // R2 protect low
        {1'b1, 1'b0, 1'b1, 4'h2, 8'h00, 8'h82, 1'b0}, // R2 wrong address
        {1'b1, 1'b0, 1'b1, 4'h0, 8'h34, 8'h34, 1'b0}, // R6 4M, R3 set
        {1'b1, 1'b0, 1'b1, 4'h0, 8'h00, 8'h04, 1'b0}, // R3 sticky, R6 1M
        {1'b1, 1'b0, 1'b1, 4'h0, 8'h10, 8'h04, 1'b1}, // R7 code 01
        {1'b1, 1'b0, 1'b1, 4'h0, 8'h70, 8'h34, 1'b1}, // R8 bit6 zero
        {1'b1, 1'b0, 1'b1, 4'h0, 8'h20, 8'h34, 1'b1}, // R7 code 10
        {1'b0, 1'b1, 1'b0, 4'h0, 8'h00, 8'h3D, 1'b1}, // R4 forced
        {1'b1, 1'b1, 1'b1, 4'h0, 8'h00, 8'h0D, 1'b1}, // R4 write loses
        {1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 8'h0D, 1'b1}, // R5 stays
        {1'b1, 1'b0, 1'b1, 4'h0, 8'h00, 8'h04, 1'b1}  // R5 written
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic read_at(input logic [ADDR_W-1:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog all-reqs actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        read_at(4'h0, v); check("R1 reset image", v, 8'h08);
        read_at(4'h1, v); check("R1 reset error reg", v, 8'h00);
        check("R1 area_err", {7'b0, area_err}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            prot_wen = VEC[i][23];
            flash_rw = VEC[i][22];
            wr_en    = VEC[i][21];
            addr     = VEC[i][20:17];
            wdata    = VEC[i][16:9];
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0;
            read_at(4'h0, v);
            check($sformatf("vec%0d rdata R2-R9", i), v, VEC[i][8:1]);
            check($sformatf("vec%0d R7 area_err", i), {7'b0, area_err}, {7'b0, VEC[i][0]});
        end

        // R7 error readable at its own address
        read_at(4'h1, v); check("R7 error readback", v, 8'h01);
        // R10 unmapped address
        read_at(4'h5, v); check("R10 unmapped read", v, 8'h00);
        // R3 decoded outputs after table: image 0x04
        check("R3 wdt_rst_sel", {7'b0, wdt_rst_sel}, 8'h01);
        check("R6 area_4m", {7'b0, area_4m}, 8'h00);
        check("R9 wait/port", {6'b0, wait_en, port_sel}, 8'h00);

        // R6/R9 decoded outputs for 4M with wait and port
        prot_wen = 1'b1; wr_en = 1'b1; addr = 4'h0; wdata = 8'hB2;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        check("R6 area_4m set", {7'b0, area_4m}, 8'h01);
        check("R9 wait/port set", {6'b0, wait_en, port_sel}, 8'h03);
        check("R4 blk/exp cleared", {6'b0, rsv_exp, blk_en}, 8'h00);

        // R1 reset again clears sticky bits
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_at(4'h0, v); check("R1 re-reset image", v, 8'h08);
        check("R3 wdt cleared by reset", {7'b0, wdt_rst_sel}, 8'h00);
        check("R7 err cleared by reset", {7'b0, area_err}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule